// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block is the host side of a two-wire serial debug link. It generates the debug clock and drives a bidirectional data line through an output value, an output enable and a sampled input. An external pad joins these three signals into one wire. Commands arrive on a valid/ready channel, and each one runs to completion before a result is presented on a second valid/ready channel.

Three operations are supported. A line reset holds the data line high for a fixed number of clocks. A wake-up runs a line reset, then the 16-bit code that moves a target from the scan protocol to the two-wire protocol, then a second line reset. A transfer is a single register read or write. It sends an 8-bit request, releases the line for a turnaround bit and reads back a 3-bit acknowledge. After an OK acknowledge it moves 32 data bits plus a parity bit. Every field on the wire goes least significant bit first.

Command channel: a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low from acceptance until the result has been consumed. Result channel: `rsp_valid` rises when the operation ends. The result holds steady until a clock edge where `rsp_ready` is high. The engine starts no new wire activity while a result is pending, so it throttles itself when the consumer is slow.

Top module: `swd_host_engine`

## Requirements
- R1: `cmd_op` = 0 (or the spare code 3) performs a line reset. The bench sees 56 clock periods with `swdio_oe` = 1 and `swdio_out` = 1, then a result with `rsp_ack` = 0 and all error flags clear.
- R2: `cmd_op` = 1 performs a wake-up of 128 driven bits. Bits 0–55 are 1. Bits 56–71 carry 16'hE79E, least significant bit first. Bits 72–127 are 1.
- R3: `cmd_op` = 2 starts a transfer with an 8-bit driven request, in wire order: start 1, `cmd_apndp`, `cmd_rnw`, `cmd_addr[0]`, `cmd_addr[1]`, even parity over those four, stop 0, park 1. A debug-port read at address 0 therefore sends 1,0,1,0,0,1,0,1 (byte 0xA5).
- R4: Request bit 7 is followed by one turnaround bit with `swdio_oe` = 0. Three acknowledge bits are then sampled with the line released. The first wire bit lands in `rsp_ack[0]`, so OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100.
- R5: On an OK read, 32 data bits (first bit into `rsp_rdata[0]`) and a parity bit are sampled, followed by one released turnaround bit, for 46 clocks in total. `rsp_parity_err` is 1 exactly when the sampled parity differs from the even parity of the data.
- R6: On an OK write, one released turnaround bit follows the acknowledge. `cmd_wdata` is then driven least significant bit first, followed by its even parity bit, for 46 clocks in total.
- R7: On WAIT or FAULT, one released turnaround bit follows the acknowledge and the transfer ends after 13 clocks with no data phase. The code is reported on `rsp_ack`.
- R8: An acknowledge of 3'b111 sets `rsp_noresp_err` = 1 and `rsp_proto_err` = 0, and ends the transfer after 13 clocks.
- R9: Any acknowledge other than 001, 010, 100 or 111 sets `rsp_proto_err` = 1 and `rsp_noresp_err` = 0, and ends after 13 clocks.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the result fields stay stable, `cmd_ready` stays low, a raised `cmd_valid` is not accepted and no clock pulses appear.
- R11: `swclk` is low when idle and has a period of 2×`HALF_CYC` system clocks (8 at the default). `swdio_out` and `swdio_oe` change only while `swclk` is low, and input bits are sampled at the rising edge.
- R12: After reset: `swclk` = 0, `swdio_oe` = 1, `swdio_out` = 0, `cmd_ready` = 1, `rsp_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 2 | 0 line reset, 1 wake-up, 2 transfer, 3 line reset |
| cmd_apndp | input | 1 | 1 access port, 0 debug port |
| cmd_rnw | input | 1 | 1 read, 0 write |
| cmd_addr | input | 2 | Register address bits {A3,A2} |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_ack | output | 3 | Acknowledge as sampled, first wire bit in bit 0 |
| rsp_rdata | output | 32 | Read data |
| rsp_parity_err | output | 1 | Read data parity mismatch |
| rsp_noresp_err | output | 1 | All-ones acknowledge, no target answering |
| rsp_proto_err | output | 1 | Acknowledge pattern not defined |
| swclk | output | 1 | Debug clock to target |
| swdio_out | output | 1 | Data line value when driven |
| swdio_oe | output | 1 | Data line drive enable |
| swdio_in | input | 1 | Data line as seen at the pad |

## Verification
The bench plays the target. It records every bit at each rising clock edge and feeds acknowledge and data bits back on the line. An engine that omitted or doubled the turnaround would shift every later field by one bit. That shows up as a wrong clock count of 45 or 47 instead of 46, and as misread data. The all-ones acknowledge is used to catch a design that treats a floating line as valid, or as a plain protocol error, and carries on into a 32-bit data phase. A bad read parity bit checks that the parity flag is not hard-wired. A held-off result with a command pending exposes an engine that drops or overwrites a result, or starts the next transaction early.

// File: rtl/swd_pkg.sv
package swd_pkg;

  typedef enum logic [1:0] {
    OP_LRESET = 2'd0,
    OP_WAKE   = 2'd1,
    OP_XFER   = 2'd2,
    OP_SPARE  = 2'd3
  } swd_op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SEQ, PH_HDR, PH_TRN1, PH_ACK,
    PH_RDATA, PH_RPAR, PH_TRN2, PH_WDATA, PH_WPAR, PH_DONE
  } swd_phase_e;

  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;
  localparam logic [2:0] ACK_NONE  = 3'b111;

  // request byte, bit 0 goes on the wire first
  function automatic logic [7:0] swd_header(input logic apndp, input logic rnw,
                                            input logic [1:0] addr);
    return {1'b1, 1'b0, apndp ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, apndp, 1'b1};
  endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic swclk,
  output logic rise,
  output logic bit_end
);
  localparam int CW = (HALF_CYC < 2) ? 1 : $clog2(2 * HALF_CYC);

  logic [CW-1:0] cnt;

  assign rise    = run && (cnt == CW'(HALF_CYC - 1));
  assign bit_end = run && (cnt == CW'(2 * HALF_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      swclk <= 1'b0;
    end else begin
      if (!run || bit_end) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
      if (rise)                 swclk <= 1'b1;
      else if (bit_end || !run) swclk <= 1'b0;
    end
  end

  AST_CLK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !swclk);  // R11

endmodule

// File: rtl/swd_seq_fsm.sv
module swd_seq_fsm
  import swd_pkg::*;
#(
  parameter int          RST_LEN = 56,
  parameter int          DATA_W  = 32,
  parameter logic [15:0] SW_CODE = 16'hE79E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              bit_end,
  output logic              run,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_apndp,
  input  logic              cmd_rnw,
  input  logic [1:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_parity_err,
  output logic              rsp_noresp_err,
  output logic              rsp_proto_err,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);
  localparam int SW_LEN  = 16;
  localparam int SEQ_MAX = 2 * RST_LEN + SW_LEN;
  localparam int CNT_MAX = (SEQ_MAX > DATA_W) ? SEQ_MAX : DATA_W;
  localparam int IDX_W   = $clog2(CNT_MAX + 1);
  localparam int DIW     = $clog2(DATA_W);

  swd_phase_e        phase_q;
  swd_op_e           op_q;
  logic [IDX_W-1:0]  idx_q, seq_len, sw_off;
  logic              apndp_q, rnw_q, rpar_q;
  logic [1:0]        addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [2:0]        ack_q;
  logic [7:0]        hdr;
  logic              is_xfer;

  assign hdr     = swd_header(apndp_q, rnw_q, addr_q);
  assign seq_len = (op_q == OP_WAKE) ? IDX_W'(SEQ_MAX) : IDX_W'(RST_LEN);
  assign sw_off  = idx_q - IDX_W'(RST_LEN);
  assign run     = (phase_q != PH_IDLE) && (phase_q != PH_DONE);
  assign is_xfer = (op_q == OP_XFER);

  // line drive for the bit currently on the wire
  always_comb begin
    swdio_oe  = 1'b1;
    swdio_out = 1'b0;
    unique case (phase_q)
      PH_SEQ: begin
        if (op_q == OP_WAKE && idx_q >= IDX_W'(RST_LEN) && idx_q < IDX_W'(RST_LEN + SW_LEN))
          swdio_out = SW_CODE[sw_off[3:0]];
        else
          swdio_out = 1'b1;
      end
      PH_HDR:   swdio_out = hdr[idx_q[2:0]];
      PH_TRN1, PH_ACK, PH_RDATA, PH_RPAR, PH_TRN2: swdio_oe = 1'b0;
      PH_WDATA: swdio_out = wdata_q[idx_q[DIW-1:0]];
      PH_WPAR:  swdio_out = ^wdata_q;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_LRESET;
      idx_q   <= '0;
      apndp_q <= 1'b0;
      rnw_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      ack_q   <= '0;
      rpar_q  <= 1'b0;
    end else begin
      if (rise) begin
        unique case (phase_q)
          PH_ACK:   ack_q[idx_q[1:0]] <= swdio_in;
          PH_RDATA: rdata_q[idx_q[DIW-1:0]] <= swdio_in;
          PH_RPAR:  rpar_q <= swdio_in;
          default:  ;
        endcase
      end
      unique case (phase_q)
        PH_IDLE: if (cmd_valid) begin
          op_q    <= swd_op_e'(cmd_op);
          apndp_q <= cmd_apndp;
          rnw_q   <= cmd_rnw;
          addr_q  <= cmd_addr;
          wdata_q <= cmd_wdata;
          ack_q   <= '0;
          rdata_q <= '0;
          rpar_q  <= 1'b0;
          idx_q   <= '0;
          phase_q <= (swd_op_e'(cmd_op) == OP_XFER) ? PH_HDR : PH_SEQ;
        end
        PH_DONE: if (rsp_ready) phase_q <= PH_IDLE;
        default: if (bit_end) begin
          idx_q <= idx_q + 1'b1;
          unique case (phase_q)
            PH_SEQ: if (idx_q == seq_len - 1'b1) phase_q <= PH_DONE;
            PH_HDR: if (idx_q == IDX_W'(7)) begin phase_q <= PH_TRN1; idx_q <= '0; end
            PH_TRN1: begin phase_q <= PH_ACK; idx_q <= '0; end
            PH_ACK: if (idx_q == IDX_W'(2)) begin
              idx_q   <= '0;
              phase_q <= (ack_q == ACK_OK && rnw_q) ? PH_RDATA : PH_TRN2;
            end
            PH_RDATA: if (idx_q == IDX_W'(DATA_W - 1)) phase_q <= PH_RPAR;
            PH_RPAR:  phase_q <= PH_TRN2;
            PH_TRN2: begin
              idx_q   <= '0;
              phase_q <= (!rnw_q && ack_q == ACK_OK) ? PH_WDATA : PH_DONE;
            end
            PH_WDATA: if (idx_q == IDX_W'(DATA_W - 1)) phase_q <= PH_WPAR;
            PH_WPAR:  phase_q <= PH_DONE;
            default:  ;
          endcase
        end
      endcase
    end
  end

  assign cmd_ready      = (phase_q == PH_IDLE);
  assign rsp_valid      = (phase_q == PH_DONE);
  assign rsp_ack        = ack_q;
  assign rsp_rdata      = rdata_q;
  assign rsp_noresp_err = is_xfer && (ack_q == ACK_NONE);
  assign rsp_proto_err  = is_xfer && !(ack_q inside {ACK_OK, ACK_WAIT, ACK_FAULT, ACK_NONE});
  assign rsp_parity_err = is_xfer && rnw_q && (ack_q == ACK_OK) && ((^rdata_q) != rpar_q);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ack) && $stable(rsp_rdata));  // R10
  AST_HDR_THEN_TRN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HDR && bit_end && idx_q == IDX_W'(7)) |=> (phase_q == PH_TRN1) && !swdio_oe);  // R4
  AST_NO_DATA_BAD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TRN2 && bit_end && ack_q != ACK_OK) |=> rsp_valid);  // R7
  AST_NORESP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_noresp_err && rsp_proto_err));  // R8

endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_pkg::*;
#(
  parameter int          HALF_CYC = 4,
  parameter int          RST_LEN  = 56,
  parameter int          DATA_W   = 32,
  parameter logic [15:0] SW_CODE  = 16'hE79E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_apndp,
  input  logic              cmd_rnw,
  input  logic [1:0]        cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [2:0]        rsp_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_parity_err,
  output logic              rsp_noresp_err,
  output logic              rsp_proto_err,
  output logic              swclk,
  output logic              swdio_out,
  output logic              swdio_oe,
  input  logic              swdio_in
);
  logic run, rise, bit_end;

  swd_clk_gen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .swclk(swclk), .rise(rise), .bit_end(bit_end)
  );

  swd_seq_fsm #(.RST_LEN(RST_LEN), .DATA_W(DATA_W), .SW_CODE(SW_CODE)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .bit_end(bit_end), .run(run),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_parity_err(rsp_parity_err), .rsp_noresp_err(rsp_noresp_err),
    .rsp_proto_err(rsp_proto_err),
    .swdio_out(swdio_out), .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  AST_DRIVE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    swclk && $past(swclk) |-> $stable(swdio_out) && $stable(swdio_oe));  // R11
  AST_NO_CLK_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && $past(rsp_valid) |-> !swclk);  // R10

endmodule

// File: tb/sim_swd_host_engine.sv
module sim_swd_host_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_apndp = 1'b0, cmd_rnw = 1'b0, rsp_ready = 1'b0, swdio_in = 1'b0;
  logic [1:0] cmd_op = 2'd0, cmd_addr = 2'd0;
  logic [31:0] cmd_wdata = '0;
  logic cmd_ready, rsp_valid, rsp_parity_err, rsp_noresp_err, rsp_proto_err;
  logic [2:0] rsp_ack;
  logic [31:0] rsp_rdata;
  logic swclk, swdio_out, swdio_oe;

  int n_chk = 0, n_bad = 0, cyc = 0, bitn = 0;
  int rise_cyc[2];
  logic rec_oe[256], rec_out[256], tgt[256];

  always #2 clk = ~clk;

  swd_host_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_apndp(cmd_apndp), .cmd_rnw(cmd_rnw), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
    .rsp_parity_err(rsp_parity_err), .rsp_noresp_err(rsp_noresp_err),
    .rsp_proto_err(rsp_proto_err), .swclk(swclk), .swdio_out(swdio_out),
    .swdio_oe(swdio_oe), .swdio_in(swdio_in)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // target model: record host bits at rise, present next bit at fall
  always @(posedge swclk) begin
    if (bitn < 256) begin rec_oe[bitn] = swdio_oe; rec_out[bitn] = swdio_out; end
    if (bitn < 2) rise_cyc[bitn] = cyc;
    bitn++;
  end
  always @(negedge swclk) if (bitn < 256) swdio_in = tgt[bitn];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_tgt(input logic [2:0] ack, input logic [31:0] d, input logic par);
    for (int i = 0; i < 256; i++) tgt[i] = 1'b0;
    tgt[9] = ack[0]; tgt[10] = ack[1]; tgt[11] = ack[2];
    for (int i = 0; i < 32; i++) tgt[12+i] = d[i];
    tgt[44] = par;
  endtask

  task automatic issue(input logic [1:0] op, input logic ap, input logic rw,
                       input logic [1:0] a, input logic [31:0] wd);
    @(negedge clk);
    bitn = 0; swdio_in = tgt[0];
    cmd_op = op; cmd_apndp = ap; cmd_rnw = rw; cmd_addr = a; cmd_wdata = wd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int w = 0; w < 5000 && !rsp_valid; w++) @(negedge clk);
  endtask

  task automatic release_rsp();
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic chk_hdr(input string req, input logic ap, input logic rw, input logic [1:0] a);
    logic [7:0] got, oes, exp;
    exp = {1'b1, 1'b0, ap ^ rw ^ a[0] ^ a[1], a[1], a[0], rw, ap, 1'b1};
    for (int i = 0; i < 8; i++) begin got[i] = rec_out[i]; oes[i] = rec_oe[i]; end
    chk({req, " header bits"}, 32'(got), 32'(exp));
    chk({req, " header driven"}, 32'(oes), 32'hFF);
    chk("R4 turnaround released", 32'(rec_oe[8]), 32'h0);
  endtask

  task automatic t_reset_state();
    chk("R12 swclk", 32'(swclk), 32'h0);
    chk("R12 oe", 32'(swdio_oe), 32'h1);
    chk("R12 out", 32'(swdio_out), 32'h0);
    chk("R12 ready", 32'(cmd_ready), 32'h1);
    chk("R12 rsp_valid", 32'(rsp_valid), 32'h0);
  endtask

  task automatic t_line_reset();
    int bad = 0;
    set_tgt(3'b000, 32'h0, 1'b0);
    issue(2'd0, 1'b0, 1'b0, 2'd0, 32'h0);
    for (int i = 0; i < 56; i++) if (rec_oe[i] !== 1'b1 || rec_out[i] !== 1'b1) bad++;
    chk("R1 bits high", 32'(bad), 32'h0);
    chk("R1 length", 32'(bitn), 32'd56);
    chk("R1 ack", 32'(rsp_ack), 32'h0);
    chk("R1 errors", {29'h0, rsp_parity_err, rsp_noresp_err, rsp_proto_err}, 32'h0);
    chk("R11 clock period", 32'(rise_cyc[1] - rise_cyc[0]), 32'd8);
    chk("R11 idle clock low", 32'(swclk), 32'h0);
    release_rsp();
    issue(2'd3, 1'b0, 1'b0, 2'd0, 32'h0);
    chk("R1 spare op length", 32'(bitn), 32'd56);
    release_rsp();
  endtask

  task automatic t_wakeup();
    int bad = 0;
    logic [15:0] code = 16'hE79E;
    set_tgt(3'b000, 32'h0, 1'b0);
    issue(2'd1, 1'b0, 1'b0, 2'd0, 32'h0);
    for (int i = 0; i < 128; i++) begin
      logic e = (i >= 56 && i < 72) ? code[i-56] : 1'b1;
      if (rec_oe[i] !== 1'b1 || rec_out[i] !== e) bad++;
    end
    chk("R2 sequence bits", 32'(bad), 32'h0);
    chk("R2 length", 32'(bitn), 32'd128);
    release_rsp();
  endtask

  task automatic t_read_ok();
    int bad = 0;
    logic [7:0] hb;
    logic [31:0] d = 32'h2BA0_1477;
    set_tgt(3'b001, d, ^d);
    issue(2'd2, 1'b0, 1'b1, 2'd0, 32'h0);
    for (int i = 0; i < 8; i++) hb[i] = rec_out[i];
    chk("R3 IDCODE header 0xA5", 32'(hb), 32'hA5);
    chk_hdr("R3", 1'b0, 1'b1, 2'd0);
    for (int i = 9; i < 46; i++) if (rec_oe[i] !== 1'b0) bad++;
    chk("R5 line released through read", 32'(bad), 32'h0);
    chk("R4 ack OK", 32'(rsp_ack), 32'h1);
    chk("R5 rdata", rsp_rdata, d);
    chk("R5 parity ok", 32'(rsp_parity_err), 32'h0);
    chk("R5 length", 32'(bitn), 32'd46);
    chk("R5 host drives after", 32'(swdio_oe), 32'h1);
    release_rsp();
  endtask

  task automatic t_read_parerr();
    logic [31:0] d = 32'h1234_5678;
    set_tgt(3'b001, d, ~(^d));
    issue(2'd2, 1'b1, 1'b1, 2'd1, 32'h0);
    chk_hdr("R3 AP read", 1'b1, 1'b1, 2'd1);
    chk("R5 rdata", rsp_rdata, d);
    chk("R5 parity error", 32'(rsp_parity_err), 32'h1);
    release_rsp();
  endtask

  task automatic t_write_ok();
    int bad = 0;
    logic [31:0] wd = 32'hCAFE_0135;
    set_tgt(3'b001, 32'hFFFF_FFFF, 1'b1);
    issue(2'd2, 1'b1, 1'b0, 2'd3, wd);
    chk_hdr("R3 AP write", 1'b1, 1'b0, 2'd3);
    chk("R6 turnaround", 32'(rec_oe[12]), 32'h0);
    for (int i = 0; i < 32; i++) if (rec_oe[13+i] !== 1'b1 || rec_out[13+i] !== wd[i]) bad++;
    chk("R6 data bits", 32'(bad), 32'h0);
    chk("R6 parity bit", 32'(rec_out[45]), 32'(^wd));
    chk("R6 length", 32'(bitn), 32'd46);
    chk("R6 ack", 32'(rsp_ack), 32'h1);
    release_rsp();
  endtask

  task automatic t_short(input string req, input logic [2:0] ack, input logic rw,
                         input logic noresp, input logic proto);
    if (ack == 3'b111) for (int i = 0; i < 256; i++) tgt[i] = 1'b1;
    else set_tgt(ack, 32'hA5A5_5A5A, 1'b1);
    issue(2'd2, 1'b0, rw, 2'd2, 32'hFFFF_FFFF);
    chk({req, " length"}, 32'(bitn), 32'd13);
    chk({req, " ack"}, 32'(rsp_ack), 32'(ack));
    chk({req, " trn released"}, 32'(rec_oe[12]), 32'h0);
    chk({req, " noresp flag"}, 32'(rsp_noresp_err), 32'(noresp));
    chk({req, " proto flag"}, 32'(rsp_proto_err), 32'(proto));
    release_rsp();
  endtask

  task automatic t_backpressure();
    logic [31:0] d = 32'h0F0F_3C3C;
    int b0;
    set_tgt(3'b001, d, ^d);
    issue(2'd2, 1'b0, 1'b1, 2'd3, 32'h0);
    b0 = bitn;
    cmd_op = 2'd0; cmd_valid = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 rsp held", 32'(rsp_valid), 32'h1);
    chk("R10 rdata held", rsp_rdata, d);
    chk("R10 not ready", 32'(cmd_ready), 32'h0);
    chk("R10 no clock", 32'(bitn), 32'(b0));
    cmd_valid = 1'b0;
    release_rsp();
    chk("R10 back to idle", 32'(cmd_ready), 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin tgt[i] = 1'b0; rec_oe[i] = 1'b0; rec_out[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_line_reset();
    t_wakeup();
    t_read_ok();
    t_read_parerr();
    t_write_ok();
    t_short("R7 WAIT read", 3'b010, 1'b1, 1'b0, 1'b0);
    t_short("R7 FAULT write", 3'b100, 1'b0, 1'b0, 1'b0);
    t_short("R8 no response", 3'b111, 1'b1, 1'b1, 1'b0);
    t_short("R9 bad pattern", 3'b110, 1'b1, 1'b0, 1'b1);
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule